// File: doc/BRIEF.md
# Linear Array Pixel Selection Sequencer

This block is the digital sequencer of a linear image sensor with `NPIX` pixel sites (512 by default). A read-out is started by a serial start input that is high at a rising clock edge while the block is idle. A single token then walks through the pixel-select positions, one per rising edge, in ascending order. The block drives one select strobe per pixel, a binary pixel index with a valid flag, an output-enable flag for the analog path, and the two per-cycle phase flags that reset and sample the sense node.

When the last pixel is selected, a chain output goes high for that one cycle. It can be wired to the start input of a following sensor that shares the clock, so that several devices read out one after another with no gap. The edge after the last pixel ends the read-out and disables the output. Any start seen while a read-out is running is ignored, including a start on that ending edge. A start on the very next edge after the ending edge begins a new read-out at once.

The pixel stream has a valid flag and no ready. The sensor cannot stall, because charge integration does not wait. A consumer must therefore take one index per cycle while `px_vld` is high. Back-pressure is not supported.

Top module: `lsel_sequencer`

## Requirements
- R1: `px_sel` has at most one bit high. While `px_vld` is high, the single high bit is at position `px_idx`. While `px_vld` is low, `px_sel` is all zero.
- R2: When `start_i` is high at a rising edge and the block is idle, the block captures the start. After that edge `px_vld` is 1 and `px_idx` is 0. When the block is idle and `start_i` is low, `px_vld` stays 0.
- R3: During a read-out, each further rising edge raises `px_idx` by one. Pixels are therefore presented in the order 0, 1, …, NPIX-1, one per cycle.
- R4: `chain_out` is high during exactly the one cycle in which pixel NPIX-1 is selected, counting the capturing edge as edge 1. It is low at all other times.
- R5: `ao_en` equals `px_vld`. Both fall on the edge after the one that selected pixel NPIX-1, which is edge NPIX+1 of the read-out.
- R6: A start that is high at any edge of a running read-out, including the ending edge NPIX+1, has no effect on `px_idx`, `px_sel` or `ao_en`.
- R7: A start high at edge NPIX+2 begins a new read-out on that edge, with `px_idx` = 0 and no idle cycle after the ending edge.
- R8: `rst_ph` is high while `clk` is low, in every cycle, whether or not a read-out is running.
- R9: `smp_ph` is high only while `clk` is high and `ao_en` is high. `smp_ph` and `rst_ph` are never high together.
- R10: A synchronous `rst` high at a rising edge forces the block idle. After that edge `px_sel` is all zero and `px_vld`, `ao_en` and `chain_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; everything advances on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Serial start; captured at a rising edge when idle |
| px_sel | output | NPIX | One-hot pixel select strobes |
| px_idx | output | clog2(NPIX) | Index of the selected pixel |
| px_vld | output | 1 | A pixel is selected this cycle |
| ao_en | output | 1 | Analog output enabled (low means high impedance) |
| chain_out | output | 1 | Start pulse for a following device; high while the last pixel is selected |
| rst_ph | output | 1 | Sense-node reset phase, high while clk is low |
| smp_ph | output | 1 | Sample phase, high while clk is high during read-out |

## Verification
The properties assume that `start_i` and `rst` are synchronous to `clk` and stable around its rising edge. They also assume that `clk` is a free-running clock with both phases present, because the phase flags are derived from its level. The stimulus changes `start_i` and `rst` only just after falling edges and samples outputs two time units after each edge. It holds the start high for whole cycles, including runs of many cycles, so that capture, the ignored starts and the back-to-back restart all occur on clean edges.

// File: rtl/lsel_pkg.sv
package lsel_pkg;

  typedef enum logic {
    RD_IDLE   = 1'b0,
    RD_ACTIVE = 1'b1
  } rd_state_e;

  // width of a binary index able to address n positions
  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lsel_token_chain.sv
// One-hot select token: bit 0 loads on capture, then shifts one place per edge
// and falls off the end after the last position.
module lsel_token_chain #(
  parameter int NPIX = 512
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  output logic [NPIX-1:0] tok
);

  generate
    if (NPIX > 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) tok <= '0;
        else     tok <= {tok[NPIX-2:0], load};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) tok <= '0;
        else     tok <= load;
      end
    end
  endgenerate

endmodule

// File: rtl/lsel_index_ctr.sv
// Read-out state and binary pixel index; also serves as the busy flag that
// gates start capture, so no wide OR over the token is needed.
module lsel_index_ctr
  import lsel_pkg::*;
#(
  parameter int NPIX = 512,
  parameter int IW   = idx_bits(NPIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  output logic          active,
  output logic [IW-1:0] idx,
  output logic          at_last
);

  localparam logic [IW-1:0] LAST = IW'(NPIX - 1);

  rd_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= RD_IDLE;
      idx <= '0;
    end else begin
      case (st)
        RD_IDLE: begin
          if (load) begin
            st  <= RD_ACTIVE;
            idx <= '0;
          end
        end
        RD_ACTIVE: begin
          if (idx == LAST) begin
            st  <= RD_IDLE;
            idx <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= RD_IDLE;
      endcase
    end
  end

  assign active  = (st == RD_ACTIVE);
  assign at_last = active && (idx == LAST);

endmodule

// File: rtl/lsel_phase_gen.sv
// Per-cycle sense-node phases taken from the clock level:
// reset during the low half, sample during the high half of an active read-out.
module lsel_phase_gen (
  input  logic clk,
  input  logic en,
  output logic rst_ph,
  output logic smp_ph
);

  assign rst_ph = ~clk;
  assign smp_ph = clk & en;

endmodule

// File: rtl/lsel_sequencer.sv
module lsel_sequencer #(
  parameter  int NPIX = 512,
  localparam int IW   = lsel_pkg::idx_bits(NPIX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  output logic [NPIX-1:0] px_sel,
  output logic [IW-1:0]   px_idx,
  output logic            px_vld,
  output logic            ao_en,
  output logic            chain_out,
  output logic            rst_ph,
  output logic            smp_ph
);

  logic active;
  logic at_last;
  logic load;

  // a start is honoured only from idle; this also rejects it on the ending edge
  assign load = start_i & ~active;

  lsel_token_chain #(.NPIX(NPIX)) u_tok (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .tok  (px_sel)
  );

  lsel_index_ctr #(.NPIX(NPIX), .IW(IW)) u_idx (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .active  (active),
    .idx     (px_idx),
    .at_last (at_last)
  );

  lsel_phase_gen u_ph (
    .clk    (clk),
    .en     (active),
    .rst_ph (rst_ph),
    .smp_ph (smp_ph)
  );

  assign px_vld    = active;
  assign ao_en     = active;
  assign chain_out = px_sel[NPIX-1];

endmodule

// File: rtl/lsel_sequencer_chk.sv
module lsel_sequencer_chk #(
  parameter int NPIX = 512,
  parameter int IW   = lsel_pkg::idx_bits(NPIX)
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic [NPIX-1:0] px_sel,
  input logic [IW-1:0]   px_idx,
  input logic            px_vld,
  input logic            ao_en,
  input logic            chain_out,
  input logic            rst_ph,
  input logic            smp_ph
);

  localparam logic [IW-1:0] LAST = IW'(NPIX - 1);

  a_r1_sel_matches_idx: assert property (@(posedge clk) disable iff (rst)
    $onehot0(px_sel) && (px_vld ? px_sel[px_idx] : (px_sel == '0)))
    else $error("R1 select token disagrees with index");

  a_r2_start_captured: assert property (@(posedge clk) disable iff (rst)
    (!px_vld && start_i) |=> (px_vld && px_idx == '0))
    else $error("R2 start not captured");

  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (px_vld && px_idx != LAST) |=> (px_vld && px_idx == $past(px_idx) + 1'b1))
    else $error("R3 index did not advance");

  a_r4_chain_at_last: assert property (@(posedge clk) disable iff (rst)
    chain_out == (px_vld && px_idx == LAST))
    else $error("R4 chain pulse misplaced");

  a_r5_end_disables: assert property (@(posedge clk) disable iff (rst)
    (px_vld && px_idx == LAST) |=> (!ao_en && !px_vld && px_sel == '0))
    else $error("R5 read-out did not end");

  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (!px_vld && !ao_en && !chain_out && px_sel == '0))
    else $error("R10 reset did not force idle");

  always_comb begin
    a_r9_phase_exclusive: assert (!(rst_ph && smp_ph))
      else $error("R9 reset and sample phases overlap");
  end

endmodule

bind lsel_sequencer lsel_sequencer_chk #(.NPIX(NPIX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .px_sel    (px_sel),
  .px_idx    (px_idx),
  .px_vld    (px_vld),
  .ao_en     (ao_en),
  .chain_out (chain_out),
  .rst_ph    (rst_ph),
  .smp_ph    (smp_ph)
);

// File: tb/sim_lsel_sequencer.sv
`timescale 1ns/1ps
module sim_lsel_sequencer;

  localparam int N  = 512;
  localparam int IW = lsel_pkg::idx_bits(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [N-1:0]  px_sel;
  logic [IW-1:0] px_idx;
  logic          px_vld, ao_en, chain_out, rst_ph, smp_ph;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lsel_sequencer #(.NPIX(N)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .px_sel(px_sel), .px_idx(px_idx),
    .px_vld(px_vld), .ao_en(ao_en), .chain_out(chain_out),
    .rst_ph(rst_ph), .smp_ph(smp_ph)
  );

  typedef struct {
    bit    vld;
    int    idx;
    string tag;
  } exp_t;

  exp_t q[$];

  // bench model of the read-out, fed by the driver
  bit m_busy = 1'b0;
  int m_idx  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // drive one cycle of inputs and queue the outputs expected after the next edge
  task automatic step(input bit s, input bit r);
    exp_t  e;
    string tag;
    @(negedge clk);
    start_i = s;
    rst     = r;
    if (r) begin
      tag = "R10";
      m_busy = 1'b0; m_idx = 0;
    end else if (m_busy) begin
      if (m_idx == N-1) begin
        tag = s ? "R6" : "R5";
        m_busy = 1'b0; m_idx = 0;
      end else begin
        tag = s ? "R6" : "R3";
        m_idx++;
      end
    end else if (s) begin
      tag = (q.size() > 0 && q[$].tag == "R5") || (q.size() > 0 && q[$].tag == "R6" && !q[$].vld)
            ? "R7" : "R2";
      m_busy = 1'b1; m_idx = 0;
    end else begin
      tag = "R2";
    end
    e.vld = m_busy; e.idx = m_idx; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pop one expectation per edge and compare
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(px_vld == e.vld, e.tag, "px_vld", int'(px_vld), int'(e.vld));
        check(ao_en == e.vld, "R5", "ao_en", int'(ao_en), int'(e.vld));
        if (e.vld) begin
          check(int'(px_idx) == e.idx, e.tag == "R10" ? "R3" : e.tag, "px_idx", int'(px_idx), e.idx);
          check(px_sel[e.idx] && $countones(px_sel) == 1, "R1", "px_sel ones",
                $countones(px_sel), 1);
        end else begin
          check(px_sel == '0, "R1", "px_sel ones", $countones(px_sel), 0);
        end
        check(chain_out == (e.vld && e.idx == N-1), "R4", "chain_out",
              int'(chain_out), int'(e.vld && e.idx == N-1));
        check(!rst_ph, "R8", "rst_ph high half", int'(rst_ph), 0);
        check(smp_ph == e.vld, "R9", "smp_ph high half", int'(smp_ph), int'(e.vld));
        @(negedge clk);
        #2;
        check(rst_ph, "R8", "rst_ph low half", int'(rst_ph), 1);
        check(!smp_ph, "R9", "smp_ph low half", int'(smp_ph), 0);
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R10 reset state, then R2 idle with start low
    repeat (3) step(1'b0, 1'b1);
    repeat (4) step(1'b0, 1'b0);
    // frame 1: start, stray starts mid-frame (R6) and on the ending edge (R6),
    // then a start on the next edge (R7)
    step(1'b1, 1'b0);
    for (int k = 1; k <= N + 1; k++)
      step(k == 100 || k == 101 || k == N || k == N + 1, 1'b0);
    // finish frame 2 with start low, then idle
    for (int k = 1; k <= N + 3; k++) step(1'b0, 1'b0);
    // start held high for two full frames: back-to-back restarts (R7)
    repeat (2 * N + 4) step(1'b1, 1'b0);
    // R10 reset in the middle of a read-out, then a fresh start
    step(1'b0, 1'b1);
    repeat (3) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    repeat (40) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    repeat (2) step(1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #4;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule